// File: doc/BRIEF.md
# Up-Down PWM Pair Timer with Event Flags

This block is a centre-aligned PWM timer. Its counter runs up from zero to a programmed period and then back down to zero, over and over. The counter is compared with a programmed threshold to make a raw waveform. A dead-band stage turns that waveform into a complementary pair of outputs. After any change of the raw level, both outputs are held inactive for a programmable number of clock cycles. Each output then passes through its own polarity inverter.

Four sticky event flags record what the counter has done. These events are reaching zero, reaching the period, and meeting the threshold. A threshold match sets a different flag depending on whether the counter is rising or falling. Software clears a flag by writing one to it. A per-flag enable mask combines the flags into a single interrupt line.

All settings are reached through a small synchronous write port and a combinational read port. The period and threshold written while the timer runs are held in shadow registers. They are copied into the active registers only when the counter returns to zero, so a waveform is never cut short in the middle of a cycle.

Top module: `pwm_pair_timer`

## Requirements
- R1: With the run bit set and active period P > 0, the counter visits 0, 1, …, P, P−1, …, 1, 0 and then repeats. With P = 0 it stays at 0. While the run bit is clear the counter is held at 0.
- R2: The counter direction is "down" in every cycle where the count equals P, and "up" in every cycle where the count equals 0. The direction is used to classify threshold matches.
- R3: Status bit 0 is set by every cycle in which the running count is 0. Status bit 1 is set by every cycle in which the running count equals the active period.
- R4: A cycle in which the running count equals the active threshold sets status bit 2 when the direction is up, and status bit 3 when the direction is down. It never sets both.
- R5: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 to it has no effect. If a set event and a clear write reach the same bit in the same cycle, the bit ends up set.
- R6: The interrupt output is high exactly when some status bit and its enable bit are both 1. A status bit is recorded even while its enable bit is 0.
- R7: The raw level is 1 while the count is below the active threshold. Output A follows the raw level one cycle later, and output B follows its complement one cycle later.
- R8: After each change of the raw level, both pre-inversion outputs stay at 0 for D cycles, where D is the dead-time register value. A later change restarts this window.
- R9: Output A is XORed with its own invert bit, and output B with its own invert bit, after dead-time insertion. All four combinations are allowed. While the timer is stopped, both pre-inversion outputs are 0.
- R10: Period and threshold writes take effect the next time the running counter moves to 0. While the timer is stopped they take effect in the following cycle.
- R11: Register addresses (all readable) are as follows.
  - 0: period.
  - 1: threshold.
  - 2: dead time.
  - 3: control, with bit 0 = run, bit 1 = invert A, bit 2 = invert B.
  - 4: interrupt enable in bits 3:0.
  - 5: status in bits 3:0; a write to this address clears the bits written as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data of the register at `addr` |
| pwm_a | output | 1 | Output A of the complementary pair, after inversion |
| pwm_b | output | 1 | Output B of the complementary pair, after inversion |
| irq | output | 1 | Combined, masked event interrupt |

## Verification
The bench builds the block with CNT_W = 8 and DT_W = 4. It then sweeps these settings:
- every period from 0 to 5;
- every threshold from 0 to one past the period;
- dead times of 0, 1 and 2;
- all four polarity combinations.

This small configuration brings the threshold-at-zero and threshold-at-peak matches within reach, as well as a threshold that is never reached and a dead window longer than a pulse, each in a few cycles. Pin levels and expected flags are computed from a closed-form triangle formula. Directed sequences then cover the following:
- a period change made in mid-cycle, which must wait for the zero point;
- a clear write that collides with a set event;
- interrupt masking.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

   localparam int NUM_FLAGS = 4;

   // status bit positions
   localparam int FLG_ZERO = 0;
   localparam int FLG_PEAK = 1;
   localparam int FLG_CUP  = 2;
   localparam int FLG_CDN  = 3;

   typedef enum logic [2:0] {
      REG_PERIOD  = 3'd0,
      REG_COMPARE = 3'd1,
      REG_DEAD    = 3'd2,
      REG_CTRL    = 3'd3,
      REG_IEN     = 3'd4,
      REG_STATUS  = 3'd5
   } reg_addr_e;

endpackage

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] per_shadow,
   input  logic [CNT_W-1:0] cmp_shadow,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up,
   output logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] cmp_act
);

   logic [CNT_W-1:0] nxt;
   logic             nxt_dir;

   always_comb begin
      if (per_act == '0) begin
         nxt     = '0;
         nxt_dir = 1'b1;
      end else begin
         nxt = dir_up ? cnt + 1'b1 : cnt - 1'b1;
         if (nxt == per_act)
            nxt_dir = 1'b0;
         else if (nxt == '0)
            nxt_dir = 1'b1;
         else
            nxt_dir = dir_up;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         dir_up  <= 1'b1;
         per_act <= '0;
         cmp_act <= '0;
      end else if (!run) begin
         cnt     <= '0;
         dir_up  <= 1'b1;
         per_act <= per_shadow;
         cmp_act <= cmp_shadow;
      end else begin
         cnt    <= nxt;
         dir_up <= nxt_dir;
         if (nxt == '0) begin
            per_act <= per_shadow;
            cmp_act <= cmp_shadow;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act); // R1

   AST_PEAK_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && per_act != '0 && cnt == per_act) |-> !dir_up); // R2

   AST_FLOOR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> dir_up); // R2

endmodule

// File: rtl/pwm_event_flags.sv
module pwm_event_flags #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] ev,
   input  logic [NF-1:0] clr,
   input  logic [NF-1:0] ien,
   output logic [NF-1:0] flags,
   output logic          irq
);

   for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[gi] <= 1'b0;
         else
            flags[gi] <= (flags[gi] & ~clr[gi]) | ev[gi];
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ev[gi]) |-> flags[gi]); // R5

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         $past(clr[gi] && !ev[gi]) |-> !flags[gi]); // R5
   end

   assign irq = |(flags & ien);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            raw,
   input  logic [DT_W-1:0] dead,
   input  logic [1:0]      inv,
   output logic [1:0]      pin
);

   logic            lvl;
   logic            en_q;
   logic [DT_W-1:0] dt_left;
   logic [1:0]      pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl     <= 1'b0;
         en_q    <= 1'b0;
         dt_left <= '0;
      end else begin
         en_q <= run;
         if (!run) begin
            lvl     <= 1'b0;
            dt_left <= '0;
         end else if (raw != lvl) begin
            lvl     <= raw;
            dt_left <= dead;
         end else if (dt_left != '0) begin
            dt_left <= dt_left - 1'b1;
         end
      end
   end

   assign pre[0] = en_q &  lvl & (dt_left == '0);
   assign pre[1] = en_q & ~lvl & (dt_left == '0);

   for (genvar gi = 0; gi < 2; gi++) begin : g_pol
      assign pin[gi] = pre[gi] ^ inv[gi];
   end

   AST_A_AFTER_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre[0]) |-> $past(raw) && $past(run)); // R7

   AST_B_AFTER_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre[1]) |-> !$past(raw) && $past(run)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run) |-> pre == 2'b00); // R9

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
   import pwm_pair_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   output logic             pwm_a,
   output logic             pwm_b,
   output logic             irq
);

   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwm_pair_timer: CNT_W must lie in 4..32");
   end
   if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt_w
      $error("pwm_pair_timer: DT_W must lie in 1..CNT_W");
   end

   logic [CNT_W-1:0]     per_sh, cmp_sh;
   logic [DT_W-1:0]      dead_r;
   logic                 run, inv_a, inv_b;
   logic [NUM_FLAGS-1:0] ien, flags, ev, clr;
   logic [CNT_W-1:0]     cnt, per_act, cmp_act;
   logic                 dir_up, match;
   logic [1:0]           pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh <= '0;
         cmp_sh <= '0;
         dead_r <= '0;
         run    <= 1'b0;
         inv_a  <= 1'b0;
         inv_b  <= 1'b0;
         ien    <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(addr))
            REG_PERIOD:  per_sh <= wr_data;
            REG_COMPARE: cmp_sh <= wr_data;
            REG_DEAD:    dead_r <= wr_data[DT_W-1:0];
            REG_CTRL:    {inv_b, inv_a, run} <= wr_data[2:0];
            REG_IEN:     ien <= wr_data[NUM_FLAGS-1:0];
            default: ;
         endcase
      end
   end

   assign clr = (wr_en && addr == REG_STATUS) ? wr_data[NUM_FLAGS-1:0] : '0;

   always_comb begin
      case (reg_addr_e'(addr))
         REG_PERIOD:  rd_data = per_sh;
         REG_COMPARE: rd_data = cmp_sh;
         REG_DEAD:    rd_data = CNT_W'(dead_r);
         REG_CTRL:    rd_data = CNT_W'({inv_b, inv_a, run});
         REG_IEN:     rd_data = CNT_W'(ien);
         REG_STATUS:  rd_data = CNT_W'(flags);
         default:     rd_data = '0;
      endcase
   end

   pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .per_shadow (per_sh),
      .cmp_shadow (cmp_sh),
      .cnt        (cnt),
      .dir_up     (dir_up),
      .per_act    (per_act),
      .cmp_act    (cmp_act)
   );

   assign match         = run && (cnt == cmp_act);
   assign ev[FLG_ZERO]  = run && (cnt == '0);
   assign ev[FLG_PEAK]  = run && (cnt == per_act);
   assign ev[FLG_CUP]   = match &&  dir_up;
   assign ev[FLG_CDN]   = match && !dir_up;

   pwm_event_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .clr   (clr),
      .ien   (ien),
      .flags (flags),
      .irq   (irq)
   );

   pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .raw   (cnt < cmp_act),
      .dead  (dead_r),
      .inv   ({inv_b, inv_a}),
      .pin   (pins)
   );

   assign pwm_a = pins[0];
   assign pwm_b = pins[1];

   AST_PEAK_MATCH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && per_act != '0 && cnt == cmp_act && cnt == per_act) |=> flags[FLG_CDN]); // R4

   AST_ZERO_MATCH_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '0 && cmp_act == '0) |=> flags[FLG_CUP]); // R4

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flags != '0); // R6

endmodule

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;

   localparam int CW = 8;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data;
   logic          pwm_a, pwm_b, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   pwm_pair_timer #(.CNT_W(CW), .DT_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns after the next falling edge
   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      addr    = 3'(a);
      wr_data = CW'(d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      addr = 3'(a);
      #1;
      d = int'(rd_data);
   endtask

   function automatic int cnt_at(input int k, input int p);
      int m;
      if (p == 0) return 0;
      m = k % (2 * p);
      return (m <= p) ? m : 2 * p - m;
   endfunction

   function automatic bit raw_at(input int k, input int p, input int c);
      if (k < 0) return 1'b0;
      return cnt_at(k, p) < c;
   endfunction

   function automatic bit pre_at(input int k, input int p, input int c,
                                 input int d, input bit level);
      if (k < 1) return 1'b0;
      for (int j = k - 1 - d; j <= k - 1; j++)
         if (raw_at(j, p, c) != level) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int flags_for(input int p, input int c, input int n);
      int f = 0;
      for (int k = 0; k < n; k++) begin
         int v = cnt_at(k, p);
         bit up = (p == 0) ? 1'b1 : ((k % (2 * p)) < p);
         if (v == 0) f |= 1;
         if (v == p) f |= 2;
         if (v == c) f |= up ? 4 : 8;
      end
      return f;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int v;
      int ef;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R9 reset pwm_a", int'(pwm_a), 0);
      check("R9 reset pwm_b", int'(pwm_b), 0);
      check("R6 reset irq", int'(irq), 0);
      rd(5, v); check("R11 reset status", v, 0);

      // register readback (R11)
      wr(0, 3); wr(1, 2); wr(2, 5); wr(3, 6); wr(4, 9);
      rd(0, v); check("R11 period readback", v, 3);
      rd(1, v); check("R11 compare readback", v, 2);
      rd(2, v); check("R11 dead readback", v, 5);
      rd(3, v); check("R11 control readback", v, 6);
      rd(4, v); check("R11 enable readback", v, 9);
      check("R9 idle pwm_a inverted", int'(pwm_a), 1);
      check("R9 idle pwm_b inverted", int'(pwm_b), 1);
      wr(4, 0); wr(5, 15);

      // sweep: period, threshold, dead time, polarity
      for (int p = 0; p <= 5; p++)
         for (int c = 0; c <= p + 1; c++)
            for (int d = 0; d <= 2; d++)
               for (int pol = 0; pol < 4; pol++) begin
                  int n = 4 * p + 2;
                  wr(0, p); wr(1, c); wr(2, d);
                  wr(3, pol << 1);
                  wr(3, (pol << 1) | 1);
                  for (int k = 0; k < n; k++) begin
                     check("R1 R7 R8 R9 pwm_a", int'(pwm_a),
                           int'(pre_at(k, p, c, d, 1'b1) ^ pol[0]));
                     check("R1 R7 R8 R9 pwm_b", int'(pwm_b),
                           int'(pre_at(k, p, c, d, 1'b0) ^ pol[1]));
                     if (k < n - 1) @(negedge clk);
                  end
                  wr(3, pol << 1);
                  ef = flags_for(p, c, n);
                  rd(5, v); check("R2 R3 R4 status", v, ef);
                  check("R6 irq masked", int'(irq), 0);
                  wr(4, 15);
                  check("R6 irq enabled", int'(irq), int'(ef != 0));
                  wr(4, 0); wr(5, 15);
                  rd(5, v); check("R5 status cleared", v, 0);
               end

      // buffered period change and clear/set collision
      wr(3, 0); wr(0, 4); wr(1, 0); wr(2, 0); wr(5, 15);
      wr(3, 1);            // counting starts, cycle 0 (count 0)
      wr(5, 15);           // clear lands with zero/up-match events
      wr(0, 2);            // new period written at count 1
      @(negedge clk);      // cycle 3, count 3
      rd(5, v); check("R5 R10 set beats clear, old period kept", v, 5);
      repeat (6) @(negedge clk);   // cycle 9, count 1 with period 2
      wr(5, 15);
      @(negedge clk);      // cycle 11
      rd(5, v); check("R10 new period used after zero", v, 2);
      wr(3, 0);
      rd(5, v); check("R6 flag recorded while disabled", v, 2);
      check("R6 irq low with enable clear", int'(irq), 0);
      wr(4, 1);
      check("R6 irq low on other enable", int'(irq), 0);
      wr(4, 2);
      check("R6 irq high on matching enable", int'(irq), 1);
      wr(5, 1);
      rd(5, v); check("R5 write one to other bit ignored", v, 2);
      wr(5, 2);
      rd(5, v); check("R5 write one clears", v, 0);
      check("R6 irq low after clear", int'(irq), 0);

      // threshold change while running is buffered too
      wr(4, 0); wr(0, 3); wr(1, 3); wr(2, 0);
      wr(3, 1);            // cycle 0
      wr(1, 0);            // written at count 0, lands in cycle 1
      @(negedge clk);      // cycle 2, count 2, old threshold 3
      check("R10 old threshold kept", int'(pwm_a), 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule